// File: doc/BRIEF.md
# Flash-to-configuration data streamer

This block copies a configuration bitstream out of a parallel flash memory and feeds it to a device configuration port. The port can be byte-wide or one-bit serial. The block drives a word address and a read strobe toward the flash. It waits a programmable number of cycles for the flash to respond, then captures the returned word. It divides its input clock down to a configuration clock and puts each byte on that clock. When the flash bus is 16 bits wide, a single read returns two bytes.

Flash reads run in parallel with the output. The next word is fetched while the current word is still being clocked out. Each word therefore costs the larger of its fetch time and its output time. The output time depends on the port mode, the clock ratio and the compressed-data option.

All settings are captured while reset is low and stay frozen for the whole transfer. Streaming begins when reset goes high. A fixed startup wait comes first, then the transfer runs. A done flag rises after the programmed number of bytes has been sent.

Top module: `flash_cfg_streamer`

## Requirements
- R1: The ratio code k selects a configuration clock period of R = 2^k input cycles. While a byte is presented and R >= 2, `cfg_clk_o` is low for the first R/2 cycles of each period and high for the last R/2. With R = 1, `cfg_clk_o` is high during the low phase of `clk`.
- R2: In parallel mode, `cfg_data_o` carries the whole byte. An uncompressed byte is held for one period (R cycles). With the compressed option set, each byte is held for four periods (4R cycles).
- R3: In serial mode, only `cfg_data_o[0]` carries data and bits 7..1 are 0. Bits go out least significant first, one per period, so each byte takes 8R cycles. The compressed option has no effect in this mode.
- R4: Read number w (counting from 0) drives `flash_addr_o` = w. `flash_rd_o` is high for exactly L consecutive cycles, where L is the latched latency (L >= 1). The word is captured from `flash_data_i` in the L-th cycle.
- R5: With the wide option, each flash word gives two bytes: bits 7..0 go out first, then bits 15..8. The word count is ceil(N/2). If N is odd, only the low byte of the last word is sent.
- R6: Word w is presented from cycle o(w) = max(s(w)+L, o(w-1)+D(w-1)), where s(w) is its read start and D is the word's output length. The next read starts in cycle o(w). No read is issued after the last word.
- R7: Cycle 0 is the first cycle after reset is released. The first read starts in cycle 2L (with the default startup multiple of 2).
- R8: `done_o` rises in the cycle right after the final cycle of the last byte and stays high. From then on, `flash_rd_o`, `cfg_clk_o` and `cfg_data_o` stay 0.
- R9: The mode, ratio, compressed, wide, latency and byte-count inputs are sampled only while reset is low. Changing them after reset release has no effect on the output.
- R10: While reset is low, `flash_rd_o`, `cfg_clk_o`, `cfg_data_o` and `done_o` are all 0.
- R11: In any cycle where no byte is being presented (during startup or while waiting on the flash), `cfg_clk_o` and `cfg_data_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low reset; streaming starts when it goes high |
| cfg_serial_i | input | 1 | 1 = serial port, 0 = byte-parallel port |
| cfg_packed_i | input | 1 | Compressed or encrypted data (parallel mode: 4 periods per byte) |
| cfg_ratio_i | input | 2 | Clock ratio code k, R = 2^k |
| cfg_wide_i | input | 1 | 1 = 16-bit flash data bus |
| cfg_latency_i | input | LAT_W | Flash access latency L in cycles, at least 1 |
| cfg_bytes_i | input | CNT_W | Number of bytes N to send, at least 1 |
| flash_addr_o | output | ADDR_W | Flash word address |
| flash_rd_o | output | 1 | Flash read strobe |
| flash_data_i | input | FLASH_W | Flash read data |
| cfg_clk_o | output | 1 | Configuration clock |
| cfg_data_o | output | 8 | Configuration data (bit 0 only in serial mode) |
| done_o | output | 1 | Transfer complete |

## Verification
The bench builds a schedule in integer arithmetic for every configuration, working forward from the recurrence in R6. It starts from s(0) = 2L, gives each word an output length of bytes × R × (1, 4 or 8), and sets done at the end of the last word. Outputs are sampled once per cycle, one time unit after the falling edge of `clk`. Each sample is compared with that cycle's entry in the schedule, so every result is checked in the exact cycle it is due.

The flash model outputs garbage unless the current address has been read for at least L-1 earlier consecutive cycles. A capture made even one cycle early therefore shows up as wrong data.

// File: rtl/fstr_pkg.sv
package fstr_pkg;

   typedef enum logic [1:0] {
      F_WAIT,
      F_READ,
      F_HOLD,
      F_STOP
   } fetch_st_t;

   typedef struct packed {
      logic       serial;
      logic       packed_data;
      logic [1:0] rsel;
      logic       wide;
   } mode_t;

   // input cycles needed to present one byte
   function automatic logic [6:0] byte_cycles(mode_t m);
      logic [6:0] periods;
      if (m.serial)
         periods = 7'd8;
      else if (m.packed_data)
         periods = 7'd4;
      else
         periods = 7'd1;
      return periods << m.rsel;
   endfunction

endpackage

// File: rtl/fstr_cfg.sv
module fstr_cfg
   import fstr_pkg::*;
#(
   parameter int LAT_W        = 6,
   parameter int CNT_W        = 16,
   parameter int FLASH_W      = 16,
   parameter int STARTUP_MULT = 2,
   localparam int SW          = LAT_W + $clog2(STARTUP_MULT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             serial_i,
   input  logic             packed_i,
   input  logic [1:0]       ratio_i,
   input  logic             wide_i,
   input  logic [LAT_W-1:0] lat_i,
   input  logic [CNT_W-1:0] bytes_i,
   output mode_t            mode_o,
   output logic [LAT_W-1:0] lat_o,
   output logic [CNT_W-1:0] bytes_o,
   output logic [SW-1:0]    startup_o
);

   logic wide_ok;

   generate
      if (FLASH_W == 16) begin : g_wide_bus
         assign wide_ok = wide_i;
      end else begin : g_narrow_bus
         assign wide_ok = 1'b0;
      end
   endgenerate

   // settings follow the inputs only while reset is low
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_o.serial      <= serial_i;
         mode_o.packed_data <= packed_i;
         mode_o.rsel        <= ratio_i;
         mode_o.wide        <= wide_ok;
         lat_o              <= lat_i;
         bytes_o            <= bytes_i;
      end
   end

   assign startup_o = SW'(lat_o) * SW'(STARTUP_MULT);

   AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ($stable(mode_o) && $stable(lat_o) && $stable(bytes_o))); // R9
   AST_LAT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (lat_o != '0)); // R4

endmodule

// File: rtl/fstr_fetch.sv
module fstr_fetch
   import fstr_pkg::*;
#(
   parameter int ADDR_W  = 20,
   parameter int LAT_W   = 6,
   parameter int CNT_W   = 16,
   parameter int FLASH_W = 16,
   parameter int SW      = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [LAT_W-1:0]   lat_i,
   input  logic [SW-1:0]      startup_i,
   input  logic [CNT_W-1:0]   words_i,
   input  logic               take_i,
   input  logic [FLASH_W-1:0] flash_data_i,
   output logic [ADDR_W-1:0]  flash_addr_o,
   output logic               flash_rd_o,
   output logic               avail_o,
   output logic [15:0]        word_o
);

   localparam int CW = (SW > LAT_W) ? SW : LAT_W;

   fetch_st_t          st;
   logic [CW-1:0]      cnt;
   logic [FLASH_W-1:0] hold;
   logic               last_beat;
   logic               more;
   logic [FLASH_W-1:0] src;

   assign last_beat  = (st == F_READ) && (cnt == CW'(lat_i) - CW'(1));
   assign more       = (CNT_W'(flash_addr_o) + CNT_W'(1)) < words_i;
   assign avail_o    = last_beat || (st == F_HOLD);
   assign flash_rd_o = (st == F_READ);
   assign src        = (st == F_HOLD) ? hold : flash_data_i;

   generate
      if (FLASH_W == 16) begin : g_w16
         assign word_o = src;
      end else begin : g_w8
         assign word_o = {8'h00, src};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st           <= F_WAIT;
         cnt          <= '0;
         flash_addr_o <= '0;
         hold         <= '0;
      end else begin
         case (st)
            F_WAIT: begin
               if (cnt == CW'(startup_i)) begin
                  st  <= F_READ;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + CW'(1);
               end
            end
            F_READ: begin
               if (last_beat) begin
                  cnt <= '0;
                  if (take_i) begin
                     if (more) flash_addr_o <= flash_addr_o + ADDR_W'(1);
                     else      st           <= F_STOP;
                  end else begin
                     hold <= flash_data_i;
                     st   <= F_HOLD;
                  end
               end else begin
                  cnt <= cnt + CW'(1);
               end
            end
            F_HOLD: begin
               if (take_i) begin
                  if (more) begin
                     st           <= F_READ;
                     flash_addr_o <= flash_addr_o + ADDR_W'(1);
                  end else begin
                     st <= F_STOP;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   AST_RD_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (st == F_READ && cnt != '0) |-> $stable(flash_addr_o)); // R4
   AST_TAKE_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      take_i |-> avail_o); // R6

endmodule

// File: rtl/fstr_out.sv
module fstr_out
   import fstr_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  mode_t            mode_i,
   input  logic [CNT_W-1:0] bytes_i,
   input  logic             take_i,
   input  logic [15:0]      word_i,
   output logic             free_o,
   output logic             cfg_clk_o,
   output logic [7:0]       cfg_data_o,
   output logic             done_o
);

   logic             active;
   logic [15:0]      word_q;
   logic             two;
   logic             bidx;
   logic [6:0]       t;
   logic [CNT_W-1:0] consumed;
   logic [6:0]       cyc;
   logic             last;
   logic             pair;
   logic [7:0]       cur_byte;
   logic [2:0]       bit_sel;
   logic             phase;

   assign cyc    = byte_cycles(mode_i);
   assign last   = active && (t == cyc - 7'd1) && (bidx == two);
   assign free_o = !active || last;
   assign pair   = mode_i.wide && ((bytes_i - consumed) >= CNT_W'(2));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active   <= 1'b0;
         word_q   <= '0;
         two      <= 1'b0;
         bidx     <= 1'b0;
         t        <= '0;
         consumed <= '0;
         done_o   <= 1'b0;
      end else begin
         if (last && consumed == bytes_i) done_o <= 1'b1;
         if (take_i) begin
            active   <= 1'b1;
            word_q   <= word_i;
            two      <= pair;
            consumed <= consumed + (pair ? CNT_W'(2) : CNT_W'(1));
            bidx     <= 1'b0;
            t        <= '0;
         end else if (active) begin
            if (t == cyc - 7'd1) begin
               t <= '0;
               if (bidx == two) active <= 1'b0;
               else             bidx   <= 1'b1;
            end else begin
               t <= t + 7'd1;
            end
         end
      end
   end

   assign cur_byte = bidx ? word_q[15:8] : word_q[7:0];
   assign bit_sel  = 3'(t >> mode_i.rsel);
   assign phase    = (mode_i.rsel == 2'd0) ? ~clk : t[mode_i.rsel - 2'd1];

   always_comb begin
      cfg_clk_o  = active & phase;
      cfg_data_o = '0;
      if (active) begin
         if (mode_i.serial) cfg_data_o[0] = cur_byte[bit_sel];
         else               cfg_data_o    = cur_byte;
      end
   end

   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> done_o); // R8
   AST_TICK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (t < cyc)); // R2
   AST_SERIAL_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
      mode_i.serial |-> (cfg_data_o[7:1] == 7'd0)); // R3

endmodule

// File: rtl/flash_cfg_streamer.sv
module flash_cfg_streamer
   import fstr_pkg::*;
#(
   parameter int ADDR_W       = 20,
   parameter int LAT_W        = 6,
   parameter int CNT_W        = 16,
   parameter int FLASH_W      = 16,
   parameter int STARTUP_MULT = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_serial_i,
   input  logic               cfg_packed_i,
   input  logic [1:0]         cfg_ratio_i,
   input  logic               cfg_wide_i,
   input  logic [LAT_W-1:0]   cfg_latency_i,
   input  logic [CNT_W-1:0]   cfg_bytes_i,
   output logic [ADDR_W-1:0]  flash_addr_o,
   output logic               flash_rd_o,
   input  logic [FLASH_W-1:0] flash_data_i,
   output logic               cfg_clk_o,
   output logic [7:0]         cfg_data_o,
   output logic               done_o
);

   localparam int SW = LAT_W + $clog2(STARTUP_MULT + 1);

   generate
      if (FLASH_W != 8 && FLASH_W != 16) begin : g_bad_width
         $error("flash_cfg_streamer: FLASH_W must be 8 or 16");
      end
      if (STARTUP_MULT < 1) begin : g_bad_startup
         $error("flash_cfg_streamer: STARTUP_MULT must be at least 1");
      end
      if (LAT_W < 1 || CNT_W < 2 || ADDR_W < 1) begin : g_bad_sizes
         $error("flash_cfg_streamer: width parameters too small");
      end
   endgenerate

   mode_t            mode;
   logic [LAT_W-1:0] lat;
   logic [CNT_W-1:0] nbytes;
   logic [SW-1:0]    startup;
   logic [CNT_W-1:0] nwords;
   logic             avail;
   logic             free;
   logic             take;
   logic [15:0]      word;

   fstr_cfg #(
      .LAT_W(LAT_W), .CNT_W(CNT_W), .FLASH_W(FLASH_W), .STARTUP_MULT(STARTUP_MULT)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n),
      .serial_i(cfg_serial_i), .packed_i(cfg_packed_i), .ratio_i(cfg_ratio_i),
      .wide_i(cfg_wide_i), .lat_i(cfg_latency_i), .bytes_i(cfg_bytes_i),
      .mode_o(mode), .lat_o(lat), .bytes_o(nbytes), .startup_o(startup)
   );

   assign nwords = mode.wide ? ((nbytes >> 1) + CNT_W'(nbytes[0])) : nbytes;
   assign take   = avail && free;

   fstr_fetch #(
      .ADDR_W(ADDR_W), .LAT_W(LAT_W), .CNT_W(CNT_W), .FLASH_W(FLASH_W), .SW(SW)
   ) u_fetch (
      .clk(clk), .rst_n(rst_n),
      .lat_i(lat), .startup_i(startup), .words_i(nwords), .take_i(take),
      .flash_data_i(flash_data_i), .flash_addr_o(flash_addr_o),
      .flash_rd_o(flash_rd_o), .avail_o(avail), .word_o(word)
   );

   fstr_out #(
      .CNT_W(CNT_W)
   ) u_out (
      .clk(clk), .rst_n(rst_n),
      .mode_i(mode), .bytes_i(nbytes), .take_i(take), .word_i(word),
      .free_o(free), .cfg_clk_o(cfg_clk_o), .cfg_data_o(cfg_data_o), .done_o(done_o)
   );

   AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!flash_rd_o && cfg_data_o == 8'd0)); // R8
   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |-> (!flash_rd_o && !done_o)); // R10

endmodule

// File: tb/flash_cfg_streamer_test.sv
module flash_cfg_streamer_test;

   localparam int ADDR_W = 20;
   localparam int LAT_W  = 6;
   localparam int CNT_W  = 16;
   localparam int MAXW   = 64;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              serial_i = 1'b0, packed_i = 1'b0, wide_i = 1'b0;
   logic [1:0]        ratio_i = '0;
   logic [LAT_W-1:0]  lat_i = 6'd1;
   logic [CNT_W-1:0]  bytes_i = 16'd1;
   logic [ADDR_W-1:0] flash_addr;
   logic              flash_rd;
   logic [15:0]       flash_data;
   logic              cfg_clk;
   logic [7:0]        cfg_data;
   logic              done;

   always #4 clk = ~clk;

   flash_cfg_streamer uut (
      .clk(clk), .rst_n(rst_n),
      .cfg_serial_i(serial_i), .cfg_packed_i(packed_i), .cfg_ratio_i(ratio_i),
      .cfg_wide_i(wide_i), .cfg_latency_i(lat_i), .cfg_bytes_i(bytes_i),
      .flash_addr_o(flash_addr), .flash_rd_o(flash_rd), .flash_data_i(flash_data),
      .cfg_clk_o(cfg_clk), .cfg_data_o(cfg_data), .done_o(done)
   );

   int checks = 0;
   int fails  = 0;
   int seed   = 0;
   int cur_l  = 1;
   bit cur_wide = 1'b0;

   function automatic int fbyte(int i, int sd);
      return (i * 29 + sd * 7 + 3) & 255;
   endfunction

   // flash model: data is valid only in the L-th consecutive read cycle of an address
   int                seen_cnt = 0;
   logic [ADDR_W-1:0] seen_addr = '0;
   logic              seen_rd = 1'b0;
   always @(posedge clk) begin
      if (flash_rd)
         seen_cnt <= (seen_rd && flash_addr == seen_addr) ? seen_cnt + 1 : 1;
      else
         seen_cnt <= 0;
      seen_addr <= flash_addr;
      seen_rd   <= flash_rd;
   end

   always @* begin
      int run, a;
      run = (seen_rd && flash_addr == seen_addr) ? seen_cnt : 0;
      a   = int'(flash_addr);
      if (flash_rd && run >= cur_l - 1)
         flash_data = cur_wide ? {8'(fbyte(2 * a + 1, seed)), 8'(fbyte(2 * a, seed))}
                               : {8'hC3, 8'(fbyte(a, seed))};
      else
         flash_data = 16'h5A3C;
   end

   task automatic check(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // watchdog
   int wd = 0;
   always @(posedge clk) begin
      wd <= wd + 1;
      if (wd > 190000) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", wd, 190000);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   int mis[8];
   int fcy[8];
   int fac[8];
   int fex[8];

   task automatic note(int k, int c, int a, int e);
      if (a != e) begin
         if (mis[k] == 0) begin
            fcy[k] = c;
            fac[k] = a;
            fex[k] = e;
         end
         mis[k]++;
      end
   endtask

   task automatic run(int mode, int rsel, bit wide, int l, int n);
      int b, nw, cc, s0, e, first_rd;
      int s[MAXW];
      int o[MAXW];
      int d[MAXW];
      string dreq;
      b  = wide ? 2 : 1;
      nw = (n + b - 1) / b;
      cc = ((mode == 2) ? 8 : (mode == 1) ? 4 : 1) << rsel;
      s0 = 2 * l;
      for (int w = 0; w < nw; w++) begin
         int nb;
         nb   = (n - w * b >= b) ? b : n - w * b;
         d[w] = nb * cc;
         s[w] = (w == 0) ? s0 : o[w - 1];
         o[w] = s[w] + l;
         if (w > 0 && o[w - 1] + d[w - 1] > o[w]) o[w] = o[w - 1] + d[w - 1];
      end
      e = o[nw - 1] + d[nw - 1];
      for (int k = 0; k < 8; k++) mis[k] = 0;
      first_rd = -1;

      @(negedge clk);
      rst_n    = 1'b0;
      seed++;
      cur_l    = l;
      cur_wide = wide;
      serial_i = (mode == 2);
      packed_i = (mode == 1) || (mode == 2 && (seed & 1) == 1);
      ratio_i  = 2'(rsel);
      wide_i   = wide;
      lat_i    = LAT_W'(l);
      bytes_i  = CNT_W'(n);
      repeat (3) @(negedge clk);
      #1;
      check(!flash_rd && !cfg_clk && cfg_data == 8'd0 && !done, "R10", "outputs in reset",
            {flash_rd, cfg_clk, done, cfg_data}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      serial_i = ~serial_i;
      packed_i = ~packed_i;
      ratio_i  = ratio_i + 2'd1;
      wide_i   = ~wide_i;
      lat_i    = lat_i + LAT_W'(3);
      bytes_i  = bytes_i + CNT_W'(1);

      for (int c = 0; c <= e + 3; c++) begin
         int dexp, cexp, aexp, cat;
         bit rexp;
         @(negedge clk);
         #1;
         dexp = 0;
         cexp = 0;
         cat  = 3;
         for (int w = 0; w < nw; w++) begin
            if (c >= o[w] && c < o[w] + d[w]) begin
               int t, bi, tb, by;
               t  = c - o[w];
               bi = t / cc;
               tb = t % cc;
               by = fbyte(w * b + bi, seed);
               dexp = (mode == 2) ? ((by >> (tb >> rsel)) & 1) : by;
               cexp = (rsel == 0) ? 1 : ((tb >> (rsel - 1)) & 1);
               cat  = (bi == 1) ? 2 : 1;
            end
         end
         rexp = 1'b0;
         aexp = 0;
         for (int w = 0; w < nw; w++) begin
            if (c >= s[w] && c < s[w] + l) begin
               rexp = 1'b1;
               aexp = w;
            end
         end
         if (flash_rd && first_rd < 0) first_rd = c;
         if (c >= e) begin
            note(7, c, {flash_rd, cfg_clk, cfg_data}, 0);
            note(6, c, done, 1);
         end else begin
            note(6, c, done, 0);
            note(cat, c, cfg_data, dexp);
            if (cat == 3) note(3, c, cfg_clk, 0);
            else          note(0, c, cfg_clk, cexp);
            note(4, c, flash_rd, rexp);
            if (rexp) note(5, c, int'(flash_addr), aexp);
         end
      end

      dreq = (mode == 2) ? "R3" : "R2";
      check(mis[0] == 0, "R1", $sformatf("cfg_clk cycle %0d", fcy[0]), fac[0], fex[0]);
      check(mis[1] == 0, dreq, $sformatf("cfg_data cycle %0d", fcy[1]), fac[1], fex[1]);
      if (wide)
         check(mis[2] == 0, "R5", $sformatf("upper byte cycle %0d", fcy[2]), fac[2], fex[2]);
      check(mis[3] == 0, "R11", $sformatf("idle output cycle %0d", fcy[3]), fac[3], fex[3]);
      check(mis[4] == 0, "R6", $sformatf("read strobe cycle %0d", fcy[4]), fac[4], fex[4]);
      check(mis[5] == 0, "R4", $sformatf("flash address cycle %0d", fcy[5]), fac[5], fex[5]);
      check(first_rd == s0, "R7", "first read cycle", first_rd, s0);
      check(mis[6] == 0, "R8", $sformatf("done cycle %0d", fcy[6]), fac[6], fex[6]);
      check(mis[7] == 0, "R8", $sformatf("quiet after done cycle %0d", fcy[7]), fac[7], fex[7]);
      check((mis[0] + mis[1] + mis[2] + mis[4]) == 0, "R9",
            "trace after input change", mis[0] + mis[1] + mis[2] + mis[4], 0);
   endtask

   initial begin
      for (int mode = 0; mode < 3; mode++)
         for (int rsel = 0; rsel < 4; rsel++)
            for (int wide = 0; wide < 2; wide++)
               for (int li = 0; li < 3; li++)
                  run(mode, rsel, wide[0], (li == 0) ? 1 : (li == 1) ? 4 : 9, 5);
      run(0, 0, 1'b1, 2, 1);
      run(0, 0, 1'b1, 20, 2);
      run(2, 1, 1'b0, 3, 1);
      run(1, 3, 1'b1, 60, 4);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule